// File: doc/BRIEF.md
# DMA Transfer Count Unit with Reload

This block keeps the transfer count for one DMA channel. Software loads a 16-bit count register. An activation copies that value into a separate working down-counter. Each completed transfer unit takes one off the working counter. When the last unit completes, the block emits a one-cycle end pulse. The channel then either goes idle, or, if reload was armed at activation, puts the original count back into the count register and waits for a restart request.

The programmed value zero stands for the largest possible run, 2^16 transfers. For this reason the working counter is one bit wider than the count register, and the current count output shows the true number of units still to go.

Software may rewrite the count register while a run is in progress. That write never touches the working counter. With reload armed, the terminal count overwrites the written value with the one saved at activation. Without reload, the written value is used by the next activation. A waiting channel leaves the waiting state only through a restart or a reset.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, the current count is 0, and busy, waiting and the end pulse are all low.
- R2: An activation pulse while the channel is neither busy nor waiting loads the working counter from the count register (a nonzero value N gives a current count of N) and raises busy on the next clock edge.
- R3: A count register value of 0 loads the working counter with 65536, so a run performs 65536 transfer units.
- R4: Each transfer-unit-done pulse while busy lowers the current count by exactly one on the next edge.
- R5: The end pulse is high for exactly one cycle: the same cycle as the unit-done that completes the final unit (current count 1). It is combinational from that input. After it, the current count is 0 and busy is low.
- R6: If reload-enable was low at activation, the channel is idle after the end pulse, with busy and waiting both low.
- R7: If reload-enable was high at activation, the activation value is saved into the reload register. After the end pulse, waiting is high and busy is low. A restart while waiting loads the working counter from the count register (which now holds the saved value), raises busy and clears waiting.
- R8: A write to the count register while busy leaves the current count unchanged. Without reload, the written value is loaded by the next activation. With reload, it is replaced by the saved value at terminal count.
- R9: Ignored inputs: unit-done while idle or waiting does not change the count; restart while idle does not raise busy; activation while busy or waiting does not reload the working counter.
- R10: Reload-enable is sampled only at activation. Changing it during a run does not change whether the channel waits or stops.
- R11: When a count register write falls in the same cycle as the final unit-done of a reload-armed run, the reload value takes precedence.
- R12: Busy and waiting are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the count register |
| cfg_wdata | input | CNT_W | Value written to the count register |
| reload_en | input | 1 | Reload request, sampled at activation |
| start | input | 1 | Activation pulse |
| unit_done | input | 1 | One transfer unit completed |
| restart | input | 1 | Restart request for a waiting channel |
| count_cur | output | CNT_W+1 | Transfer units still to perform |
| busy | output | 1 | Run in progress |
| tc_pulse | output | 1 | End-of-transfer pulse, one cycle |
| wait_restart | output | 1 | Reloaded and waiting for restart |

## Verification
Two register updates can land in the same cycle. One is a software write to the count register. The other is the reload that restores the count register at terminal count. The bench provokes this collision by raising the write strobe together with the final unit-done of a reload-armed run. It judges the winner after a restart, by the value loaded into the working counter: the saved activation value must appear, not the written one. The same run also checks that a write made mid-run leaves the current count untouched in that cycle.

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             reload_en,
  input  logic             start,
  input  logic             unit_done,
  input  logic             restart,
  output logic [CNT_W:0]   count_cur,
  output logic             busy,
  output logic             tc_pulse,
  output logic             wait_restart
);

  localparam int WRK_W = CNT_W + 1;
  localparam logic [WRK_W-1:0] FULL_RUN = WRK_W'(1) << CNT_W;
  localparam logic [WRK_W-1:0] ONE      = WRK_W'(1);

  logic [CNT_W-1:0] cnt_reg;
  logic [CNT_W-1:0] rld_reg;
  logic [WRK_W-1:0] work;
  logic             busy_q;
  logic             wait_q;
  logic             armed_q;

  function automatic logic [WRK_W-1:0] expand(input logic [CNT_W-1:0] v);
    return (v == '0) ? FULL_RUN : {1'b0, v};
  endfunction

  wire go     = start & ~busy_q & ~wait_q;
  wire resume = restart & wait_q;
  wire step   = busy_q & unit_done;
  wire last   = step & (work == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_reg <= '0;
      rld_reg <= '0;
      armed_q <= 1'b0;
    end else begin
      if (last && armed_q)   cnt_reg <= rld_reg;
      else if (cfg_wr)       cnt_reg <= cfg_wdata;
      if (go && reload_en)   rld_reg <= cnt_reg;
      if (go)                armed_q <= reload_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work   <= '0;
      busy_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (go || resume) work <= expand(cnt_reg);
      else if (step)    work <= work - ONE;
      if (go || resume) busy_q <= 1'b1;
      else if (last)    busy_q <= 1'b0;
      if (resume)                wait_q <= 1'b0;
      else if (last && armed_q)  wait_q <= 1'b1;
    end
  end

  assign count_cur    = work;
  assign busy         = busy_q;
  assign wait_restart = wait_q;
  assign tc_pulse     = last;

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && unit_done && count_cur > ONE) |=> (count_cur == $past(count_cur) - ONE));

  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> (!busy && !tc_pulse && count_cur == '0));

  p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && armed_q) |=> wait_restart);

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !armed_q) |=> (!wait_restart && !busy));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !unit_done) |=> $stable(count_cur));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !restart) |=> $stable(count_cur));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, wait_restart}));

endmodule

// File: tb/xfer_count_unit_tb.sv
`timescale 1ns/1ps
module xfer_count_unit_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, reload_en = 0, start = 0, unit_done = 0, restart = 0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic [CNT_W:0] count_cur;
  logic busy, tc_pulse, wait_restart;
  logic tc_seen;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  xfer_count_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .reload_en(reload_en), .start(start), .unit_done(unit_done),
    .restart(restart), .count_cur(count_cur), .busy(busy),
    .tc_pulse(tc_pulse), .wait_restart(wait_restart)
  );

  // {reload, value}
  localparam logic [CNT_W:0] VEC [5] = '{
    {1'b0, 16'd1}, {1'b0, 16'd3}, {1'b1, 16'd5}, {1'b1, 16'h0100}, {1'b0, 16'd0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [CNT_W-1:0] d, input logic st,
                     input logic dn, input logic rs);
    cfg_wr = wr; cfg_wdata = d; start = st; unit_done = dn; restart = rs;
    #1 tc_seen = tc_pulse;
    @(negedge clk);
    cfg_wr = 0; start = 0; unit_done = 0; restart = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cfg_wr = 0; start = 0; unit_done = 0; restart = 0; reload_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_units(input int n, input string req);
    bit early = 0;
    for (int k = 0; k < n - 1; k++) begin
      cyc(0, '0, 0, 1, 0);
      if (tc_seen) early = 1;
    end
    check({req, " count before last unit"}, count_cur, 1);
    check({req, " no early end pulse"}, early, 0);
    cyc(0, '0, 0, 1, 0);
    check({req, " end pulse with last unit"}, tc_seen, 1);
    #1 check({req, " end pulse one cycle"}, tc_pulse, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 count after reset", count_cur, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 waiting after reset", wait_restart, 0);
    check("R1 end pulse after reset", tc_pulse, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      int units;
      logic rl;
      do_reset();
      rl = VEC[i][CNT_W];
      units = (VEC[i][CNT_W-1:0] == 0) ? 65536 : int'(VEC[i][CNT_W-1:0]);
      cyc(1, VEC[i][CNT_W-1:0], 0, 0, 0);
      reload_en = rl;
      cyc(0, '0, 1, 0, 0);
      check(units == 65536 ? "R3 full run loaded" : "R2 load on activation", count_cur, units);
      check("R2 busy after activation", busy, 1);
      if (units > 1) begin
        cyc(0, '0, 0, 1, 0);
        check("R4 one decrement", count_cur, units - 1);
        run_units(units - 1, "R5");
      end else begin
        run_units(1, "R5");
      end
      check("R5 count zero after end", count_cur, 0);
      check("R5 busy low after end", busy, 0);
      check(rl ? "R7 waiting after end" : "R6 idle after end", wait_restart, rl);
      if (rl) begin
        cyc(0, '0, 0, 0, 1);
        check("R7 restart reloads", count_cur, units);
        check("R7 busy after restart", busy, 1);
        check("R7 waiting cleared", wait_restart, 0);
      end
    end

    // R8 / R11 with reload
    do_reset();
    cyc(1, 16'd4, 0, 0, 0);
    reload_en = 1;
    cyc(0, '0, 1, 0, 0);
    reload_en = 0;
    cyc(1, 16'd9, 0, 0, 0);
    check("R8 write while busy keeps count", count_cur, 4);
    cyc(0, '0, 1, 0, 0);
    check("R9 activation while busy ignored", count_cur, 4);
    repeat (3) cyc(0, '0, 0, 1, 0);
    cyc(1, 16'd7, 0, 1, 0);
    check("R11 end pulse with write", tc_seen, 1);
    check("R10 still waits after reload_en dropped", wait_restart, 1);
    cyc(0, '0, 0, 1, 0);
    check("R9 unit_done while waiting ignored", count_cur, 0);
    cyc(0, '0, 1, 0, 0);
    check("R9 activation while waiting ignored", busy, 0);
    cyc(0, '0, 0, 0, 1);
    check("R11 reload wins over same-cycle write", count_cur, 4);

    // R8 without reload, R10 raise mid-run
    do_reset();
    cyc(0, '0, 0, 1, 0);
    check("R9 unit_done while idle ignored", count_cur, 0);
    cyc(0, '0, 0, 0, 1);
    check("R9 restart while idle ignored", busy, 0);
    cyc(1, 16'd2, 0, 0, 0);
    cyc(0, '0, 1, 0, 0);
    reload_en = 1;
    cyc(1, 16'd6, 0, 0, 0);
    check("R8 write while busy keeps count", count_cur, 2);
    repeat (2) cyc(0, '0, 0, 1, 0);
    check("R10 stops despite late reload_en", wait_restart, 0);
    check("R12 busy low when stopped", busy, 0);
    reload_en = 0;
    cyc(0, '0, 1, 0, 0);
    check("R8 next activation uses written value", count_cur, 6);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule